// File: doc/BRIEF.md
# Event-Counting Reload Down Timer

This block is a down-counter whose clock enable comes from the outside world. It does not step on the system clock. It steps once for each qualified edge of an asynchronous count input. The count input is first brought into the clock domain by a flop synchronizer. An edge qualifier then picks out either rising or falling transitions. Software arms the counter by raising the count enable and pulsing a trigger. One cycle after the trigger, the stored reload value enters the counter.

A qualified edge that arrives while the counter holds zero is an underflow. On an underflow the counter takes the reload value again and keeps counting. The same event sets a sticky status flag and inverts a toggle output, so the toggle output gives a waveform whose period is a fixed number of input events. The interrupt request is the status flag gated by an interrupt enable. Software clears the flag with a one-cycle clear strobe.

Top module: `ert_timer`

## Requirements
- R1: While the timer is running, each qualified edge of `count_in` lowers `count_val` by exactly one when it is non-zero.
- R2: With `edge_sel` = 0 only rising edges of `count_in` are qualified. With `edge_sel` = 1 only falling edges are qualified. The opposite edge leaves `count_val` unchanged.
- R3: A `trig` pulse sampled while `cnt_en` is 1 loads the reload register into `count_val` on the following clock edge and starts the timer. This also holds when `cnt_en` rises in the same cycle as `trig`, and when the timer is already running. The reload register takes `reload_din` on a `reload_wr` strobe.
- R4: A qualified edge while `count_val` is 0x0000 is an underflow. The counter takes the reload value, and `uf_flag` becomes 1.
- R5: `tog_out` inverts on every underflow and holds its level otherwise.
- R6: `irq` is 1 exactly while both `uf_flag` and `irq_en` are 1.
- R7: `uf_flag` stays 1 until a `flag_clr` strobe. A clear in the same cycle as an underflow leaves the flag at 1.
- R8: While `cnt_en` is 0, `count_val` holds and both edges and triggers are ignored. After `cnt_en` returns to 1, edges are counted only after a new trigger.
- R9: A pulse on `count_in` that is at least 4 cycles high and 4 cycles low is counted exactly once. Its effect appears on `count_val` after the third clock edge following the input transition.
- R10: After reset, `count_val` = 0x0000, the reload register = 0x0000, and `uf_flag`, `irq` and `tog_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count enable level |
| trig | input | 1 | One-cycle software trigger |
| edge_sel | input | 1 | 0 selects rising edges, 1 selects falling edges |
| irq_en | input | 1 | Interrupt enable |
| reload_wr | input | 1 | Write strobe for the reload register |
| reload_din | input | CNT_W | Reload value written on `reload_wr` |
| flag_clr | input | 1 | One-cycle strobe that clears the underflow flag |
| count_in | input | 1 | Asynchronous external count input |
| count_val | output | CNT_W | Current counter value |
| uf_flag | output | 1 | Sticky underflow flag |
| irq | output | 1 | Interrupt request |
| tog_out | output | 1 | Output that toggles on each underflow |

## Verification
The bench sweeps small reload values from 0 upward with both edge selections. For every pulse it predicts the counter, the flag and the toggle level arithmetically, so a counter that reloads one event early or late drifts out of step within one period. Directed cases cover the following:
- It measures the three-edge latency from input transition to count. A missing synchronizer stage, or one too many, moves the update by a cycle.
- It checks that the opposite edge has no effect. A double-edge detector would count every pulse twice.
- It times a flag clear onto the same cycle as an underflow. A design that gives the clear priority would drop the event.
- It checks that triggers and edges are ignored while the timer is disabled, and that re-enabling without a trigger does not resume counting.

// File: rtl/ert_pkg.sv
package ert_pkg;

   // Which edge qualifier is built into the timer
   typedef enum logic [1:0] {
      EDGE_RUNTIME   = 2'd0,  // edge chosen at run time by edge_sel
      EDGE_RISE_ONLY = 2'd1,  // rising edges only
      EDGE_FALL_ONLY = 2'd2   // falling edges only
   } edge_cfg_e;

endpackage

// File: rtl/ert_edge_qual.sv
module ert_edge_qual
   import ert_pkg::*;
#(
   parameter int        SYNC_STAGES = 2,
   parameter edge_cfg_e EDGE_CFG    = EDGE_RUNTIME
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   input  logic fall_sel,
   output logic edge_o
);

   localparam int PIPE_W = SYNC_STAGES + 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("ert_edge_qual: SYNC_STAGES must be at least 2");
      end
   endgenerate

   // Synchronizer stages, plus one more stage that delays the synchronized value
   logic [PIPE_W-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[PIPE_W-2:0], din};
   end

   logic synced, delayed, rise, fall;
   assign synced  = pipe[SYNC_STAGES-1];
   assign delayed = pipe[SYNC_STAGES];
   assign rise    = synced & ~delayed;
   assign fall    = ~synced & delayed;

   generate
      if (EDGE_CFG == EDGE_RISE_ONLY) begin : g_rise
         logic unused_sel;
         assign unused_sel = fall_sel ^ fall;
         assign edge_o     = rise;
      end else if (EDGE_CFG == EDGE_FALL_ONLY) begin : g_fall
         logic unused_sel;
         assign unused_sel = fall_sel ^ rise;
         assign edge_o     = fall;
      end else begin : g_runtime
         assign edge_o = fall_sel ? fall : rise;
      end
   endgenerate

   // A synchronized level change produces a single-cycle pulse
   assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      edge_o |=> !edge_o)
      else $error("edge qualifier pulse lasted more than one cycle");

endmodule

// File: rtl/ert_down_core.sv
module ert_down_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             trig,
   input  logic             edge_i,
   input  logic             reload_wr,
   input  logic [CNT_W-1:0] reload_din,
   output logic [CNT_W-1:0] count_o,
   output logic             uf_o
);

   localparam logic [CNT_W-1:0] ZERO = '0;

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("ert_down_core: CNT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] reload_q;
   logic             trig_q;
   logic             run_q;
   logic             load;
   logic             step;
   logic             at_zero;

   assign load    = en & trig_q;
   assign step    = en & run_q & edge_i & ~trig_q;
   assign at_zero = (count_o == ZERO);
   assign uf_o    = step & at_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         reload_q <= '0;
      else if (reload_wr) reload_q <= reload_din;
   end

   // The trigger is registered, so the load happens one cycle after it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_q <= 1'b0;
         run_q  <= 1'b0;
      end else begin
         trig_q <= en & trig;
         if (!en)         run_q <= 1'b0;
         else if (trig_q) run_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       count_o <= '0;
      else if (load)    count_o <= reload_q;
      else if (step) begin
         if (at_zero)   count_o <= reload_q;
         else           count_o <= count_o - 1'b1;
      end
   end

   assert_step_dec_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !at_zero) |=> (count_o == $past(count_o) - 1'b1))
      else $error("qualified edge did not decrement by one");

   assert_trig_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (count_o == $past(reload_q)))
      else $error("trigger did not load the reload value");

   assert_uf_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
      uf_o |=> (count_o == $past(reload_q)))
      else $error("underflow did not reload");

   assert_hold_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(count_o))
      else $error("counter moved while disabled");

endmodule

// File: rtl/ert_event_flags.sv
module ert_event_flags #(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic uf_i,
   input  logic clr_i,
   input  logic irq_en,
   output logic flag_o,
   output logic tog_o,
   output logic irq_o
);

   // A new underflow has priority over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_o <= 1'b0;
      else if (uf_i)   flag_o <= 1'b1;
      else if (clr_i)  flag_o <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     tog_o <= 1'b0;
      else if (uf_i)  tog_o <= ~tog_o;
   end

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= flag_o & irq_en;
         end
         assign irq_o = irq_q;
      end else begin : g_irq_comb
         assign irq_o = flag_o & irq_en;
      end
   endgenerate

   assert_tog_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
      uf_i |=> (tog_o != $past(tog_o)))
      else $error("toggle output missed an underflow");

   assert_tog_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !uf_i |=> $stable(tog_o))
      else $error("toggle output moved without underflow");

   assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      uf_i |=> flag_o)
      else $error("underflow did not set the flag");

   assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr_i) |=> flag_o)
      else $error("flag dropped without a clear");

endmodule

// File: rtl/ert_timer.sv
module ert_timer
   import ert_pkg::*;
#(
   parameter int        CNT_W       = 16,
   parameter int        SYNC_STAGES = 2,
   parameter edge_cfg_e EDGE_CFG    = EDGE_RUNTIME,
   parameter bit        IRQ_REG     = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en,
   input  logic             trig,
   input  logic             edge_sel,
   input  logic             irq_en,
   input  logic             reload_wr,
   input  logic [CNT_W-1:0] reload_din,
   input  logic             flag_clr,
   input  logic             count_in,
   output logic [CNT_W-1:0] count_val,
   output logic             uf_flag,
   output logic             irq,
   output logic             tog_out
);

   logic qual_edge;
   logic uf_pulse;

   ert_edge_qual #(
      .SYNC_STAGES (SYNC_STAGES),
      .EDGE_CFG    (EDGE_CFG)
   ) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .din      (count_in),
      .fall_sel (edge_sel),
      .edge_o   (qual_edge)
   );

   ert_down_core #(
      .CNT_W (CNT_W)
   ) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (cnt_en),
      .trig       (trig),
      .edge_i     (qual_edge),
      .reload_wr  (reload_wr),
      .reload_din (reload_din),
      .count_o    (count_val),
      .uf_o       (uf_pulse)
   );

   ert_event_flags #(
      .IRQ_REG (IRQ_REG)
   ) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .uf_i   (uf_pulse),
      .clr_i  (flag_clr),
      .irq_en (irq_en),
      .flag_o (uf_flag),
      .tog_o  (tog_out),
      .irq_o  (irq)
   );

endmodule

// File: tb/ert_timer_tb_top.sv
module ert_timer_tb_top;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cnt_en = 1'b0, trig = 1'b0, edge_sel = 1'b0, irq_en = 1'b0;
   logic         reload_wr = 1'b0, flag_clr = 1'b0, count_in = 1'b0;
   logic [W-1:0] reload_din = '0;
   logic [W-1:0] count_val;
   logic         uf_flag, irq, tog_out;

   int  n_chk = 0, n_fail = 0;
   bit  done = 1'b0;
   logic tog_exp = 1'b0;

   always #10 clk = ~clk;  // 50 MHz

   ert_timer dut_i (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .trig(trig), .edge_sel(edge_sel),
      .irq_en(irq_en), .reload_wr(reload_wr), .reload_din(reload_din),
      .flag_clr(flag_clr), .count_in(count_in), .count_val(count_val),
      .uf_flag(uf_flag), .irq(irq), .tog_out(tog_out)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_reload(input logic [W-1:0] v);
      @(negedge clk); reload_din = v; reload_wr = 1'b1;
      @(negedge clk); reload_wr = 1'b0;
   endtask

   task automatic pulse_trig();
      @(negedge clk); trig = 1'b1;
      @(negedge clk); trig = 1'b0;
      @(negedge clk);
   endtask

   task automatic clear_flag();
      @(negedge clk); flag_clr = 1'b1;
      @(negedge clk); flag_clr = 1'b0;
   endtask

   task automatic ext_pulse();
      @(negedge clk); count_in = 1'b1;
      cyc(4);
      count_in = 1'b0;
      cyc(4);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      cyc(3);
      // R10 reset state
      chk("R10 count", count_val, 0);
      chk("R10 flag", uf_flag, 0);
      chk("R10 irq", irq, 0);
      chk("R10 tog", tog_out, 0);
      @(negedge clk); rst_n = 1'b1;
      cyc(2);
      chk("R10 reload reg", count_val, 0);

      // R3 enable and trigger in the same cycle, then check the load latency
      write_reload(16'd7);
      @(negedge clk); cnt_en = 1'b1; trig = 1'b1;
      @(negedge clk); trig = 1'b0;
      chk("R3 no load on sampling edge", count_val, 0);
      @(negedge clk);
      chk("R3 load one cycle later", count_val, 7);

      // R9 latency of three clock edges and a single count per pulse
      @(negedge clk); count_in = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R9 not yet counted", count_val, 7);
      @(negedge clk);
      chk("R9 counted on third edge", count_val, 6);
      cyc(4); count_in = 1'b0; cyc(4);
      chk("R9 counted once", count_val, 6);

      // R2 opposite edge has no effect
      write_reload(16'd9); pulse_trig();
      @(negedge clk); count_in = 1'b1; cyc(4);
      chk("R2 rise counted", count_val, 8);
      count_in = 1'b0; cyc(4);
      chk("R2 fall ignored in rising mode", count_val, 8);
      edge_sel = 1'b1;
      @(negedge clk); count_in = 1'b1; cyc(4);
      chk("R2 rise ignored in falling mode", count_val, 8);
      count_in = 1'b0; cyc(4);
      chk("R2 fall counted", count_val, 7);
      edge_sel = 1'b0;

      // R3 retrigger while running
      write_reload(16'd20); pulse_trig();
      for (int i = 0; i < 3; i++) ext_pulse();
      chk("R1 three pulses", count_val, 17);
      pulse_trig();
      chk("R3 retrigger reload", count_val, 20);

      // R8 disabled: hold, ignore trigger and edges, need a new trigger after re-enable
      @(negedge clk); cnt_en = 1'b0;
      write_reload(16'd5);
      pulse_trig();
      chk("R8 trigger ignored", count_val, 20);
      ext_pulse();
      chk("R8 edge ignored", count_val, 20);
      @(negedge clk); cnt_en = 1'b1;
      ext_pulse();
      chk("R8 no count before trigger", count_val, 20);
      pulse_trig();
      chk("R8 trigger after enable", count_val, 5);
      ext_pulse();
      chk("R8 counting resumes", count_val, 4);

      // Sweep over reload values and both edge modes (R1 R4 R5 R7)
      for (int e = 0; e < 2; e++) begin
         for (int r = 0; r < 5; r++) begin
            int  cur;
            bit  fl;
            edge_sel = e[0];
            write_reload(r[W-1:0]);
            pulse_trig();
            clear_flag();
            cur = r; fl = 1'b0;
            chk("R3 sweep load", count_val, r);
            for (int n = 0; n < 2 * r + 3; n++) begin
               ext_pulse();
               if (cur == 0) begin
                  cur = r; fl = 1'b1; tog_exp = ~tog_exp;
               end else begin
                  cur = cur - 1;
               end
               chk("R1 R4 sweep count", count_val, cur);
               chk("R5 sweep toggle", tog_out, tog_exp);
               chk("R7 sweep flag", uf_flag, fl);
            end
         end
      end
      edge_sel = 1'b0;

      // R6 interrupt gating with the flag set
      chk("R6 flag set before gating", uf_flag, 1);
      @(negedge clk); irq_en = 1'b0; @(negedge clk);
      chk("R6 irq masked", irq, 0);
      irq_en = 1'b1; @(negedge clk);
      chk("R6 irq raised", irq, 1);
      clear_flag();
      chk("R7 clear", uf_flag, 0);
      chk("R6 irq follows clear", irq, 0);

      // R7 clear in the same cycle as an underflow, with reload 0
      write_reload(16'd0); pulse_trig();
      @(negedge clk); count_in = 1'b1;
      @(negedge clk);
      @(negedge clk); flag_clr = 1'b1;
      @(negedge clk); flag_clr = 1'b0;
      tog_exp = ~tog_exp;
      chk("R7 underflow beats clear", uf_flag, 1);
      chk("R4 reload zero", count_val, 0);
      chk("R5 toggle on coincident underflow", tog_out, tog_exp);
      cyc(4); count_in = 1'b0; cyc(4);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule